// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter with Chunked Refill

This block sends frames that a host supplies on a serial B-channel bit line. The host writes the address, control and information bytes into a 128-byte byte store. The bytes wait there until the host issues a start command, which releases everything written so far. Framing is automatic. The frame begins with a 0x7E delimiter. Each byte goes out least significant bit first, with a zero inserted after every run of five ones. The ones complement of a CRC-16 follows the data, and a closing delimiter ends the frame. Between frames the line carries a continuous stream of delimiters.

A frame longer than the store is sent in chunks. After a start command without the end-of-message qualifier, the block raises a one-cycle refill pulse as soon as the free space exceeds the selected threshold (64 or 96 bytes). The host answers by writing up to one threshold of further bytes and issuing another start command. The last chunk is released by a start command with the end-of-message qualifier. If the released bytes run out before that qualifier arrives, the block aborts the frame with eight ones, pulses an underrun flag, discards everything it holds and falls back to sending delimiters.

The line advances one bit on each clock where `bit_en` is high. Every output is a register.

Top module: `hdlc_tx_refill`

## Requirements
- R1: After reset, `tx_bit` is 1 and `refill_irq` and `underrun` are 0. With nothing released, the line repeats 0x7E, least significant bit first. Each clock edge with `bit_en` high puts exactly one new bit on `tx_bit`, and that bit is visible from that edge onward.
- R2: A written byte is not transmitted until a later `cmd_start` releases it. A byte written in the same cycle as `cmd_start` is not released by that command.
- R3: A frame starts at the next delimiter boundary after bytes are released. The bits sent are the released bytes least significant bit first, then 16 bits of the complemented CRC least significant bit first, then 0x7E. The CRC uses the reflected polynomial 0x8408 (x^16+x^12+x^5+1), is preset to 0xFFFF, and covers the data bits only.
- R4: In data and CRC bits, a 0 is inserted after every five consecutive ones, including a run that ends at the last CRC bit. Delimiters and abort ones are never stuffed.
- R5: A start command without the end-of-message qualifier arms the refill request. While it is armed, `refill_irq` pulses for one cycle, one clock after the first edge at which the free space is greater than the threshold (64 when `thr_sel`=0, 96 when `thr_sel`=1), and the request is then disarmed.
- R6: A start command with the end-of-message qualifier disarms the refill request. That final chunk produces no refill pulse.
- R7: If a byte boundary inside a frame finds no released byte and no end-of-message qualifier, the block sends eight ones. `underrun` is high for exactly one cycle, all stored bytes (released or not) are discarded, and at least one full delimiter follows before any new frame.
- R8: Writes while 128 bytes are held are dropped and never transmitted.
- R9: `tx_bit` does not change at an edge where `bit_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte to store |
| cmd_start | input | 1 | Release written bytes / start or continue a frame |
| cmd_eom | input | 1 | Qualifier on cmd_start: this chunk ends the frame |
| thr_sel | input | 1 | Refill threshold: 0 selects 64 bytes, 1 selects 96 bytes |
| bit_en | input | 1 | Line bit strobe, advance one bit |
| tx_bit | output | 1 | Serial line output |
| refill_irq | output | 1 | One-cycle request for another chunk |
| underrun | output | 1 | One-cycle pulse when a frame is aborted for lack of data |

## Verification
The line bit, the refill pulse and the underrun pulse all come from registers, so each one is due one clock after the edge that caused it. For the line bit that edge is the strobed edge. For the refill pulse it is the edge at which the free space was already above the threshold while armed. For the underrun pulse it is the strobed edge carrying the last bit of the final byte. The bench model steps once on each rising edge, using the inputs held since the previous falling edge. It decides in that step exactly what the registers take, and the bench compares all three outputs at the following falling edge. Byte-boundary decisions in the model are made on the strobe that empties its bit queue, with a pending stuffed zero consumed before the next queued bit. This matches the edge at which the block loads a new byte.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {S_FLAG, S_DATA, S_CRC, S_ABORT} ser_state_t;

  localparam logic [7:0]  DELIM    = 8'h7E;
  localparam logic [15:0] CRC_POLY = 16'h8408;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // one serial step of the reflected CRC-16
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[15:1]} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/tx_byte_store.sv
module tx_byte_store #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          commit,
  input  logic          pop,
  input  logic          flush,
  output logic [W-1:0]  rd_data,
  output logic          avail,
  output logic [AW:0]   fill
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr, rel_ptr, rd_nxt;
  logic         wr_ok;

  assign fill  = wr_ptr - rd_ptr;
  assign wr_ok = wr_en && (fill != (AW+1)'(DEPTH));
  assign avail = (rel_ptr != rd_ptr);

  always_comb begin
    if (flush)    rd_nxt = wr_ptr;
    else if (pop) rd_nxt = rd_ptr + (AW+1)'(1);
    else          rd_nxt = rd_ptr;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  // registered read of the next head entry
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_nxt[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rel_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr + (AW+1)'(wr_ok);
      rd_ptr <= rd_nxt;
      if (commit || flush) rel_ptr <= wr_ptr;
    end
  end
endmodule

// File: rtl/tx_refill_req.sv
module tx_refill_req #(
  parameter int AW = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        eom,
  input  logic        abort,
  input  logic [AW:0] free,
  input  logic [AW:0] thr,
  output logic        irq
);
  logic armed, fire;

  assign fire = armed && (free > thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= fire;
      if (start)              armed <= !eom;
      else if (fire || abort) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       avail,
  input  logic [7:0] byte_in,
  input  logic       eom,
  output logic       pop,
  output logic       flush,
  output logic       eom_clr,
  output logic       underrun,
  output logic       tx_bit,
  output logic [2:0] ones_o
);
  ser_state_t  state;
  logic [15:0] sh, crc, crc_n;
  logic [3:0]  cnt;
  logic [2:0]  ones;
  logic        stuff, cur, last, in_frame;

  assign stuff    = (ones == 3'd5);
  assign cur      = sh[0];
  assign last     = bit_en && !stuff && (cnt == 4'd0);
  assign crc_n    = crc_step(crc, cur);
  assign in_frame = (state == S_DATA) || (state == S_CRC);
  assign pop      = last && avail && ((state == S_FLAG) || (state == S_DATA));
  assign flush    = last && (state == S_DATA) && !avail && !eom;
  assign eom_clr  = last && (((state == S_FLAG) && !avail) || (state == S_CRC) || flush);
  assign ones_o   = ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_FLAG;
      sh       <= {8'h00, DELIM};
      cnt      <= 4'd7;
      ones     <= 3'd0;
      crc      <= CRC_SEED;
      tx_bit   <= 1'b1;
      underrun <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (bit_en) begin
        if (stuff) begin
          tx_bit <= 1'b0;
          ones   <= 3'd0;
        end else begin
          tx_bit <= cur;
          sh     <= sh >> 1;
          cnt    <= cnt - 4'd1;
          ones   <= (in_frame && cur) ? ones + 3'd1 : 3'd0;
          if (state == S_DATA) crc <= crc_n;
          if (cnt == 4'd0) begin
            if ((state == S_FLAG || state == S_DATA) && avail) begin
              if (state == S_FLAG) crc <= CRC_SEED;
              state <= S_DATA;
              sh    <= {8'h00, byte_in};
              cnt   <= 4'd7;
            end else if (state == S_DATA && eom) begin
              state <= S_CRC;
              sh    <= ~crc_n;
              cnt   <= 4'd15;
            end else if (state == S_DATA) begin
              state    <= S_ABORT;
              sh       <= 16'h00FF;
              cnt      <= 4'd7;
              underrun <= 1'b1;
            end else begin
              state <= S_FLAG;
              sh    <= {8'h00, DELIM};
              cnt   <= 4'd7;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_refill.sv
module hdlc_tx_refill #(
  parameter int DEPTH  = 128,
  parameter int THR_LO = 64,
  parameter int THR_HI = 96,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_start,
  input  logic       cmd_eom,
  input  logic       thr_sel,
  input  logic       bit_en,
  output logic       tx_bit,
  output logic       refill_irq,
  output logic       underrun
);
  logic [AW:0] fill, free, thr;
  logic [7:0]  head;
  logic        avail, pop, flush, eom_clr, eom_lat;
  logic [2:0]  ser_ones;

  assign free = (AW+1)'(DEPTH) - fill;
  assign thr  = thr_sel ? (AW+1)'(THR_HI) : (AW+1)'(THR_LO);

  always_ff @(posedge clk) begin
    if (rst)                         eom_lat <= 1'b0;
    else if (cmd_start && cmd_eom)   eom_lat <= 1'b1;
    else if (eom_clr)                eom_lat <= 1'b0;
  end

  tx_byte_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .commit(cmd_start), .pop(pop), .flush(flush),
    .rd_data(head), .avail(avail), .fill(fill)
  );

  tx_refill_req #(.AW(AW)) u_req (
    .clk(clk), .rst(rst), .start(cmd_start), .eom(cmd_eom), .abort(flush),
    .free(free), .thr(thr), .irq(refill_irq)
  );

  tx_serializer u_ser (
    .clk(clk), .rst(rst), .bit_en(bit_en), .avail(avail), .byte_in(head),
    .eom(eom_lat), .pop(pop), .flush(flush), .eom_clr(eom_clr),
    .underrun(underrun), .tx_bit(tx_bit), .ones_o(ser_ones)
  );
endmodule

// File: rtl/hdlc_tx_refill_chk.sv
module hdlc_tx_refill_chk #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input logic        clk,
  input logic        rst,
  input logic        bit_en,
  input logic        tx_bit,
  input logic        refill_irq,
  input logic        underrun,
  input logic [AW:0] fill,
  input logic [AW:0] free,
  input logic [AW:0] thr,
  input logic [2:0]  ser_ones
);
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit)); // R9

  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bit_en && ser_ones == 3'd5) |=> !tx_bit); // R4

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    ser_ones <= 3'd5); // R4

  AST_IRQ_VACANCY: assert property (@(posedge clk) disable iff (rst)
    refill_irq |-> $past(free > thr)); // R5

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH)); // R8
endmodule

bind hdlc_tx_refill hdlc_tx_refill_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .tx_bit(tx_bit),
  .refill_irq(refill_irq), .underrun(underrun),
  .fill(fill), .free(free), .thr(thr), .ser_ones(ser_ones)
);

// File: tb/sim_hdlc_tx_refill.sv
module sim_hdlc_tx_refill;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, cmd_start = 1'b0, cmd_eom = 1'b0, thr_sel = 1'b0, bit_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_bit, refill_irq, underrun;

  int n_cmp = 0, n_bad = 0, cycles = 0, en_mode = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_refill u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_start(cmd_start), .cmd_eom(cmd_eom), .thr_sel(thr_sel),
    .bit_en(bit_en), .tx_bit(tx_bit), .refill_irq(refill_irq), .underrun(underrun)
  );

  // ---------------- behavioural reference ----------------
  byte unsigned m_q[$];
  bit          m_bits[$];
  int          m_rel = 0, m_ones = 0, m_type = 0; // 0 delim, 1 data, 2 crc, 3 abort
  bit          m_eom = 0, m_arm = 0, m_valid = 0;
  logic [15:0] m_crc = 16'hFFFF;
  logic        e_bit = 1'b1, e_irq = 1'b0, e_unr = 1'b0;

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input byte unsigned v);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ v[i]) == 1'b1) r = (r >> 1) ^ 16'h8408;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  task automatic push_unit(input logic [15:0] v, input int nb, input int t);
    for (int i = 0; i < nb; i++) m_bits.push_back(v[i]);
    m_type = t;
  endtask

  task automatic take_byte();
    byte unsigned v;
    v = m_q.pop_front();
    m_rel--;
    m_crc = ref_crc(m_crc, v);
    push_unit({8'h00, v}, 8, 1);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete(); m_bits.delete();
      push_unit(16'h007E, 8, 0);
      m_rel = 0; m_ones = 0; m_eom = 0; m_arm = 0; m_crc = 16'hFFFF;
      e_bit = 1'b1; e_irq = 1'b0; e_unr = 1'b0; m_valid = 1;
    end else begin
      bit was_full, fire, abort_now, b;
      was_full  = (m_q.size() == DEPTH);
      fire      = m_arm && ((DEPTH - m_q.size()) > (thr_sel ? 96 : 64));
      e_irq     = fire;
      e_unr     = 1'b0;
      abort_now = 0;
      if (bit_en) begin
        if (m_ones == 5) begin
          e_bit = 1'b0; m_ones = 0;
        end else begin
          b = m_bits.pop_front();
          e_bit = b;
          m_ones = ((m_type == 1 || m_type == 2) && b) ? m_ones + 1 : 0;
          if (m_bits.size() == 0) begin
            case (m_type)
              0: if (m_rel > 0) begin m_crc = 16'hFFFF; take_byte(); end
                 else begin push_unit(16'h007E, 8, 0); m_eom = 0; end
              1: if (m_rel > 0) take_byte();
                 else if (m_eom) push_unit(~m_crc, 16, 2);
                 else begin
                   push_unit(16'h00FF, 8, 3);
                   e_unr = 1'b1; abort_now = 1;
                   m_q.delete(); m_rel = 0; m_eom = 0;
                 end
              default: begin push_unit(16'h007E, 8, 0); if (m_type == 2) m_eom = 0; end
            endcase
          end
        end
      end
      if (fire || abort_now) m_arm = 0;
      if (cmd_start) begin
        m_arm = !cmd_eom;
        if (cmd_eom) m_eom = 1;
        m_rel = m_q.size();
      end
      if (wr_en && !was_full) m_q.push_back(wr_data);
    end
  end

  // ---------------- comparison ----------------
  task automatic cmp(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  bit saw_irq = 0, saw_unr = 0;
  always @(negedge clk) begin
    cycles++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (en_mode)
      0: bit_en = 1'b1;
      1: bit_en = lfsr[0] | lfsr[3];
      default: bit_en = lfsr[0] & lfsr[5];
    endcase
    if (!rst && m_valid) begin
      cmp("tx_bit", tx_bit, e_bit);
      cmp("refill_irq", refill_irq, e_irq);
      cmp("underrun", underrun, e_unr);
      if (refill_irq) saw_irq = 1;
      if (underrun) saw_unr = 1;
    end
  end

  // ---------------- host tasks ----------------
  task automatic wr(input byte unsigned v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_n(input int n, input int seed);
    for (int i = 0; i < n; i++) wr(byte'((i * 37 + seed) ^ ((i % 5 == 0) ? 8'hFF : 8'h3C)));
  endtask

  task automatic go(input bit eom);
    cmd_start = 1'b1; cmd_eom = eom;
    @(negedge clk);
    cmd_start = 1'b0; cmd_eom = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 20000; i++) begin
      if (refill_irq) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40000; i++) begin
      if (m_type == 0 && m_rel == 0 && !m_eom) break;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic count(input string req, input bit ok, input string msg);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0 expected 1", req, msg);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    count("R1", tx_bit === 1'b1, "tx_bit reset");
    count("R1", refill_irq === 1'b0, "refill_irq reset");
    count("R1", underrun === 1'b0, "underrun reset");
    rst = 1'b0;
    repeat (40) @(negedge clk);

    // R2: held bytes stay unsent; byte written with start is not released
    cur_req = "R2";
    wr_n(5, 1);
    repeat (80) @(negedge clk);
    cmd_start = 1'b1; cmd_eom = 1'b1; wr_en = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    cmd_start = 1'b0; cmd_eom = 1'b0; wr_en = 1'b0;
    wait_idle();
    go(1'b1);
    wait_idle();

    // R3 / R4: frame rich in long runs of ones
    cur_req = "R4";
    wr(8'hFF); wr(8'hFF); wr(8'h7E); wr(8'h1F); wr(8'hF8); wr(8'h00); wr(8'hBE);
    go(1'b1);
    wait_idle();
    cur_req = "R3";
    for (int i = 0; i < 9; i++) wr(byte'(8'h31 + i));
    go(1'b1);
    wait_idle();

    // R5: chunked frame, threshold 64
    cur_req = "R5";
    en_mode = 1; thr_sel = 1'b0; saw_irq = 0;
    wr_n(100, 7);
    go(1'b0);
    for (int k = 0; k < 2; k++) begin
      wait_irq();
      wr_n(64, 11 + k);
      go(1'b0);
    end
    wait_irq();
    count("R5", saw_irq, "refill pulse seen at threshold 64");
    wr_n(10, 3);
    go(1'b1);
    wait_idle();

    // R5: threshold 96
    thr_sel = 1'b1; saw_irq = 0;
    wr_n(40, 21);
    go(1'b0);
    wait_irq();
    count("R5", saw_irq, "refill pulse seen at threshold 96");
    wr_n(96, 5);
    go(1'b0);
    wait_irq();
    wr_n(5, 9);
    go(1'b1);
    wait_idle();

    // R6: final chunk alone gives no refill pulse
    cur_req = "R6";
    thr_sel = 1'b0; saw_irq = 0;
    wr_n(8, 2);
    go(1'b1);
    wait_idle();
    count("R6", !saw_irq, "no refill pulse on end-of-message chunk");

    // R7: starve a frame, then a new frame after the abort
    cur_req = "R7";
    saw_unr = 0;
    wr_n(6, 4);
    go(1'b0);
    wr_n(3, 8);
    for (int i = 0; i < 3000; i++) begin
      if (saw_unr) break;
      @(negedge clk);
    end
    count("R7", saw_unr, "underrun pulse after starvation");
    repeat (30) @(negedge clk);
    wr_n(3, 6);
    go(1'b1);
    wait_idle();

    // R8: overfill, extra bytes dropped
    cur_req = "R8";
    en_mode = 0;
    wr_n(130, 13);
    go(1'b1);
    wait_idle();

    // R9: sparse strobe
    cur_req = "R9";
    en_mode = 2;
    wr(8'hFF); wr(8'hF0); wr(8'h0F);
    go(1'b1);
    wait_idle();

    finish_run();
  end

  initial begin
    wait (cycles >= 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule